// File: doc/BRIEF.md
# Single-Precision to Fixed-Point Converter

This block turns a 32-bit IEEE-754 single-precision operand into a fixed-point integer. The integer has a run-time number of fraction bits. The result is 16 or 32 bits wide, signed or unsigned, and out-of-range values clamp to the nearest representable bound. An operand presented with `valid_i` is converted in one registered stage: the result and the exception flags appear on the cycle after the input.

There are three exception flags. The invalid flag marks a NaN operand or a result that had to be clamped. The inexact flag marks a result that lost fraction bits when it was truncated. The denormal flag marks a subnormal operand that was replaced by zero because flush-to-zero was enabled. Each flag is a single-cycle pulse that goes with the output valid. The block keeps no sticky copy, so the surrounding datapath must accumulate the flags if it needs them.

Top module: `f2fix_conv`

## Requirements
- R1: `valid_o` is high exactly one cycle after a cycle with `valid_i` high. The flags pulse only together with `valid_o`. `result_o` holds its last value while no conversion completes. After reset, all outputs are zero.
- R2: When `ftz_i` is 1 and the operand's exponent field (bits 30:23) is zero with a nonzero mantissa (bits 22:0), the operand is treated as a zero of the same sign and `denorm_o` pulses. When `ftz_i` is 0, such an operand converts by its true tiny value and `denorm_o` stays low.
- R3: The operand is multiplied by 2^`frac_bits_i` (0 to 32) exactly, with no rounding of its own.
- R4: The scaled value is truncated toward zero. Negative values are in two's complement.
- R5: `inexact_o` pulses when the truncation discarded a nonzero fraction and no saturation happened.
- R6: A NaN operand (exponent field all ones, nonzero mantissa) gives result 0 with `invalid_o` high and `inexact_o` low.
- R7: In signed mode (`signed_i`=1), a truncated value outside -32768..32767 (`half_i`=1) or -2^31..2^31-1 (`half_i`=0) is replaced by the nearer bound.
- R8: In unsigned mode, a truncated value below zero gives 0. A truncated value above 65535 (`half_i`=1) or 2^32-1 (`half_i`=0) gives that maximum. A negative operand whose truncated value is zero is in range.
- R9: Whenever a result is clamped, `invalid_o` pulses and `inexact_o` stays low.
- R10: An infinity is out of range. It clamps to the bound on its own sign's side, with `invalid_o` high.
- R11: In 16-bit modes, bits 31:16 of `result_o` hold the sign extension of bit 15 (signed) or zeros (unsigned).
- R12: A zero operand of either sign gives result 0 with no flag raised, whatever `frac_bits_i` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand and controls are valid this cycle |
| op_i | input | 32 | Single-precision operand |
| frac_bits_i | input | 6 | Number of fraction bits in the result, 0 to 32 |
| signed_i | input | 1 | 1: signed result, 0: unsigned result |
| half_i | input | 1 | 1: 16-bit result, 0: 32-bit result |
| ftz_i | input | 1 | Flush subnormal operands to zero |
| valid_o | output | 1 | Conversion result valid |
| result_o | output | 32 | Fixed-point result (16-bit results extended) |
| invalid_o | output | 1 | NaN operand or clamped result |
| inexact_o | output | 1 | Nonzero fraction discarded |
| denorm_o | output | 1 | Subnormal operand was flushed |

## Verification
The hardest cases to reach are at the edges of the ranges. One is a value that lands exactly on a bound, for example -2^31 in signed 32-bit mode, which must not clamp. Others sit just past a bound. Another is a negative fraction in unsigned mode, which must report inexact and not invalid. Uniform random bit patterns almost never produce these, because most exponents are far too large or far too small. The random stimulus therefore draws exponents from a window around the result width and the fraction-bit count, and directed cases pin down exact bounds, the infinities, NaN, signed zeros and subnormals with and without flushing. Every result is compared with a bench model that does the conversion in real arithmetic.

// File: rtl/f2fix_pkg.sv
package f2fix_pkg;
  localparam int EXP_W   = 8;
  localparam int MAN_W   = 23;
  localparam int FLT_W   = 1 + EXP_W + MAN_W;
  localparam int SIG_W   = MAN_W + 1;
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_MAX = (1 << EXP_W) - 1;
  localparam int OUT_W   = 32;
  localparam int HALF_W  = 16;
  localparam int FB_W    = $clog2(OUT_W + 1);
  localparam int E_W     = EXP_W + 3;

  typedef struct packed {
    logic                  sign;
    logic                  nan;
    logic                  inf;
    logic                  zero;
    logic [SIG_W-1:0]      sig;
    logic signed [E_W-1:0] exp;
  } fp_fields_t;
endpackage

// File: rtl/f2fix_unpack.sv
module f2fix_unpack
  import f2fix_pkg::*;
(
  input  logic [FLT_W-1:0] op_i,
  input  logic             ftz_i,
  output fp_fields_t       fields_o,
  output logic             denorm_o
);
  logic [EXP_W-1:0] e;
  logic [MAN_W-1:0] m;
  logic             e_zero, e_ones, m_zero;

  assign e      = op_i[MAN_W +: EXP_W];
  assign m      = op_i[MAN_W-1:0];
  assign e_zero = (e == '0);
  assign e_ones = (e == EXP_W'(EXP_MAX));
  assign m_zero = (m == '0);

  assign denorm_o = ftz_i & e_zero & ~m_zero;

  always_comb begin
    fields_o.sign = op_i[FLT_W-1];
    fields_o.nan  = e_ones & ~m_zero;
    fields_o.inf  = e_ones & m_zero;
    // flushed subnormals behave as signed zero
    fields_o.zero = e_zero & (m_zero | ftz_i);
    fields_o.sig  = {~e_zero, m};
    fields_o.exp  = e_zero ? E_W'(1 - BIAS) : E_W'(int'(e) - BIAS);
  end
endmodule

// File: rtl/f2fix_scale.sv
module f2fix_scale
  import f2fix_pkg::*;
(
  input  fp_fields_t       fields_i,
  input  logic [FB_W-1:0]  frac_bits_i,
  output logic [OUT_W-1:0] mag_o,
  output logic             lost_o,
  output logic             huge_o
);
  localparam int EXT_W = 2 * SIG_W;

  logic signed [E_W-1:0] e_scaled;
  logic [E_W-1:0]        lsh, rsh;
  logic [EXT_W-1:0]      ext;

  // scaling adds to the exponent only, so it is exact
  assign e_scaled = fields_i.exp + $signed(E_W'({1'b0, frac_bits_i}));

  always_comb begin
    mag_o  = '0;
    lost_o = 1'b0;
    huge_o = 1'b0;
    lsh    = '0;
    rsh    = '0;
    ext    = '0;
    if (fields_i.zero) begin
      mag_o = '0;
    end else if (e_scaled >= $signed(E_W'(OUT_W))) begin
      huge_o = 1'b1;
    end else if (e_scaled >= $signed(E_W'(MAN_W))) begin
      lsh   = E_W'(e_scaled - $signed(E_W'(MAN_W)));
      mag_o = OUT_W'(fields_i.sig) << lsh;
    end else begin
      rsh = E_W'($signed(E_W'(MAN_W)) - e_scaled);
      if (rsh > E_W'(SIG_W)) begin
        lost_o = |fields_i.sig;
      end else begin
        ext    = {fields_i.sig, {SIG_W{1'b0}}} >> rsh;
        mag_o  = OUT_W'(ext[EXT_W-1:SIG_W]);
        lost_o = |ext[SIG_W-1:0];
      end
    end
  end
endmodule

// File: rtl/f2fix_sat.sv
module f2fix_sat
  import f2fix_pkg::*;
(
  input  logic             sign_i,
  input  logic             nan_i,
  input  logic             inf_i,
  input  logic             huge_i,
  input  logic             lost_i,
  input  logic [OUT_W-1:0] mag_i,
  input  logic             signed_i,
  input  logic             half_i,
  output logic [OUT_W-1:0] result_o,
  output logic             invalid_o,
  output logic             inexact_o
);
  localparam logic [OUT_W-1:0] U_FULL_MAX = {OUT_W{1'b1}};
  localparam logic [OUT_W-1:0] S_FULL_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] S_FULL_NEG = {1'b1, {(OUT_W-1){1'b0}}};
  localparam logic [OUT_W-1:0] U_HALF_MAX = {{(OUT_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
  localparam logic [OUT_W-1:0] S_HALF_MAX = {{(OUT_W-HALF_W+1){1'b0}}, {(HALF_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] S_HALF_NEG = {{(OUT_W-HALF_W){1'b0}}, 1'b1, {(HALF_W-1){1'b0}}};

  // pos_lim: largest positive magnitude, neg_lim: largest negative magnitude
  logic [OUT_W-1:0] pos_lim, neg_lim;
  logic             over;

  always_comb begin
    unique case ({signed_i, half_i})
      2'b11:   begin pos_lim = S_HALF_MAX; neg_lim = S_HALF_NEG; end
      2'b10:   begin pos_lim = S_FULL_MAX; neg_lim = S_FULL_NEG; end
      2'b01:   begin pos_lim = U_HALF_MAX; neg_lim = '0;         end
      default: begin pos_lim = U_FULL_MAX; neg_lim = '0;         end
    endcase
  end

  assign over = huge_i | inf_i | (sign_i ? (mag_i > neg_lim) : (mag_i > pos_lim));

  always_comb begin
    if (nan_i) begin
      result_o  = '0;
      invalid_o = 1'b1;
      inexact_o = 1'b0;
    end else if (over) begin
      result_o  = sign_i ? (~neg_lim + 1'b1) : pos_lim;
      invalid_o = 1'b1;
      inexact_o = 1'b0;
    end else begin
      result_o  = sign_i ? (~mag_i + 1'b1) : mag_i;
      invalid_o = 1'b0;
      inexact_o = lost_i;
    end
  end
endmodule

// File: rtl/f2fix_conv.sv
module f2fix_conv
  import f2fix_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [FLT_W-1:0] op_i,
  input  logic [FB_W-1:0]  frac_bits_i,
  input  logic             signed_i,
  input  logic             half_i,
  input  logic             ftz_i,
  output logic             valid_o,
  output logic [OUT_W-1:0] result_o,
  output logic             invalid_o,
  output logic             inexact_o,
  output logic             denorm_o
);
  fp_fields_t       fields;
  logic             denorm_d, lost, huge, inv_d, inx_d;
  logic [OUT_W-1:0] mag, res_d;

  f2fix_unpack u_unpack (
    .op_i     (op_i),
    .ftz_i    (ftz_i),
    .fields_o (fields),
    .denorm_o (denorm_d)
  );

  f2fix_scale u_scale (
    .fields_i    (fields),
    .frac_bits_i (frac_bits_i),
    .mag_o       (mag),
    .lost_o      (lost),
    .huge_o      (huge)
  );

  f2fix_sat u_sat (
    .sign_i    (fields.sign),
    .nan_i     (fields.nan),
    .inf_i     (fields.inf),
    .huge_i    (huge),
    .lost_i    (lost),
    .mag_i     (mag),
    .signed_i  (signed_i),
    .half_i    (half_i),
    .result_o  (res_d),
    .invalid_o (inv_d),
    .inexact_o (inx_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      result_o  <= '0;
      invalid_o <= 1'b0;
      inexact_o <= 1'b0;
      denorm_o  <= 1'b0;
    end else begin
      valid_o   <= valid_i;
      invalid_o <= valid_i & inv_d;
      inexact_o <= valid_i & inx_d;
      denorm_o  <= valid_i & denorm_d;
      if (valid_i) result_o <= res_d;
    end
  end

  assert_latency_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));

  assert_flag_qual_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (invalid_o || inexact_o || denorm_o) |-> valid_o);

  assert_sat_no_inexact_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(invalid_o && inexact_o));

  assert_nan_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && (&op_i[MAN_W +: EXP_W]) && (|op_i[MAN_W-1:0]))
      |-> (result_o == '0 && invalid_o && !inexact_o));

  assert_half_sext_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && half_i && signed_i)
      |-> (result_o[OUT_W-1:HALF_W] == {(OUT_W-HALF_W){result_o[HALF_W-1]}}));

  assert_half_zext_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && half_i && !signed_i) |-> (result_o[OUT_W-1:HALF_W] == '0));

  assert_zero_in_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && op_i[FLT_W-2:0] == '0)
      |-> (result_o == '0 && !invalid_o && !inexact_o && !denorm_o));
endmodule

// File: tb/f2fix_conv_test.sv
module f2fix_conv_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] op_i = '0;
  logic [5:0]  frac_bits_i = '0;
  logic        signed_i = 1'b0, half_i = 1'b0, ftz_i = 1'b0;
  logic        valid_o, invalid_o, inexact_o, denorm_o;
  logic [31:0] result_o;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  f2fix_conv uut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (valid_i),
    .op_i        (op_i),
    .frac_bits_i (frac_bits_i),
    .signed_i    (signed_i),
    .half_i      (half_i),
    .ftz_i       (ftz_i),
    .valid_o     (valid_o),
    .result_o    (result_o),
    .invalid_o   (invalid_o),
    .inexact_o   (inexact_o),
    .denorm_o    (denorm_o)
  );

  function automatic void ref_conv(input logic [31:0] op, input int fb, input bit sg,
                                   input bit hf, input bit fz, output logic [31:0] r,
                                   output bit inv, output bit inx, output bit dn);
    int     e, m;
    bit     neg;
    longint lo, hi, t;
    real    x;
    e = int'(op[30:23]);
    m = int'(op[22:0]);
    neg = op[31];
    r = '0; inv = 0; inx = 0; dn = 0;
    if (sg) begin
      lo = hf ? -64'sd32768 : -(64'sd1 << 31);
      hi = hf ? 64'sd32767 : (64'sd1 << 31) - 1;
    end else begin
      lo = 0;
      hi = hf ? 64'sd65535 : (64'sd1 << 32) - 1;
    end
    if (e == 255 && m != 0) begin inv = 1; return; end
    if (fz && e == 0 && m != 0) begin dn = 1; m = 0; end
    if (e == 255) x = 1.0e30;
    else x = real'((e == 0) ? m : m + (1 << 23)) * (2.0 ** real'(((e == 0) ? 1 : e) - 150 + fb));
    if (neg) x = -x;
    if (x >= 1.0e12) begin r = 32'(hi); inv = 1; return; end
    if (x <= -1.0e12) begin r = 32'(lo); inv = 1; return; end
    t = longint'(x);
    if (x >= 0.0 && real'(t) > x) t = t - 1;
    if (x < 0.0 && real'(t) < x) t = t + 1;
    if (t > hi) begin r = 32'(hi); inv = 1; end
    else if (t < lo) begin r = 32'(lo); inv = 1; end
    else begin r = 32'(t); inx = (real'(t) != x); end
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic conv(input logic [31:0] op, input int fb, input bit sg, input bit hf,
                      input bit fz, input string tag);
    logic [31:0] er;
    bit ei, ex, ed;
    ref_conv(op, fb, sg, hf, fz, er, ei, ex, ed);
    @(negedge clk_i);
    op_i = op; frac_bits_i = 6'(fb); signed_i = sg; half_i = hf; ftz_i = fz; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    check({valid_o, result_o, invalid_o, inexact_o, denorm_o} == {1'b1, er, ei, ex, ed},
          tag, $sformatf("op=%h fb=%0d s=%0d h=%0d f=%0d", op, fb, sg, hf, fz),
          {valid_o, result_o, invalid_o, inexact_o, denorm_o}, {1'b1, er, ei, ex, ed});
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    check({valid_o, result_o, invalid_o, inexact_o, denorm_o} == '0, "R1", "reset",
          {valid_o, result_o, invalid_o, inexact_o, denorm_o}, '0);
    rst_ni = 1'b1;

    conv(32'h3FC00000, 0, 1, 0, 0, "R4");   // 1.5 -> 1, inexact
    conv(32'hBFC00000, 0, 1, 0, 0, "R4");   // -1.5 -> -1
    conv(32'h3FC00000, 1, 1, 0, 0, "R3");   // 1.5*2 -> 3 exact
    conv(32'h3FA00000, 2, 0, 0, 0, "R3");   // 1.25*4 -> 5
    conv(32'h3EAAAAAB, 8, 1, 1, 0, "R5");   // 1/3 with 8 fraction bits
    conv(32'h3F800000, 31, 1, 0, 0, "R7");  // 2^31 clamps
    conv(32'hBF800000, 31, 1, 0, 0, "R7");  // -2^31 fits exactly
    conv(32'h471C4000, 0, 1, 1, 0, "R7");   // 40000 half signed
    conv(32'hC71C4000, 0, 1, 1, 0, "R7");
    conv(32'h46FFFE00, 0, 1, 1, 0, "R7");   // 32767 exact
    conv(32'hC0000000, 0, 0, 0, 0, "R8");   // -2 unsigned -> 0 invalid
    conv(32'hBF000000, 0, 0, 0, 0, "R8");   // -0.5 unsigned -> 0 inexact
    conv(32'h4788B800, 0, 0, 1, 0, "R8");   // 70000 unsigned half
    conv(32'h3F800000, 32, 0, 0, 0, "R9");  // 2^32 unsigned clamps
    conv(32'h3F7FFFFF, 32, 0, 0, 0, "R9");  // just under 2^32, exact
    conv(32'h7FC00000, 5, 1, 0, 0, "R6");
    conv(32'hFF800001, 0, 0, 1, 1, "R6");
    conv(32'h7F800000, 0, 0, 0, 0, "R10");
    conv(32'hFF800000, 0, 1, 0, 0, "R10");
    conv(32'hFF800000, 3, 0, 1, 0, "R10");
    conv(32'h7F800000, 0, 1, 1, 0, "R10");
    conv(32'h00000001, 32, 1, 0, 1, "R2");
    conv(32'h80400000, 32, 0, 0, 1, "R2");
    conv(32'h00000001, 32, 1, 0, 0, "R2");
    conv(32'h807FFFFF, 32, 0, 0, 0, "R2");
    conv(32'h00000000, 32, 1, 0, 1, "R12");
    conv(32'h80000000, 17, 0, 1, 0, "R12");
    conv(32'hC0400000, 0, 1, 1, 0, "R11");  // -3 half signed
    conv(32'h40400000, 4, 0, 1, 0, "R11");

    // R1: no completion -> valid low, no flags, result held
    conv(32'h7FC00000, 0, 1, 0, 0, "R1");
    held = result_o;
    @(negedge clk_i);
    op_i = 32'h3F800000; frac_bits_i = 6'd4;
    @(negedge clk_i);
    check({valid_o, invalid_o, inexact_o, denorm_o} == 4'b0 && result_o == held, "R1", "idle hold",
          {valid_o, result_o, invalid_o, inexact_o, denorm_o}, {1'b0, held, 3'b000});

    for (int i = 0; i < 600; i++) begin
      logic [31:0] op;
      int fb, k;
      k = int'($urandom() % 16);
      fb = int'($urandom() % 33);
      op = $urandom();
      if (k < 10) op[30:23] = 8'(110 + int'($urandom() % 40) - (fb > 16 ? 16 : 0));
      else if (k == 10) op[30:23] = 8'h00;
      else if (k == 11) op[30:23] = 8'hFF;
      else if (k == 12) op[22:0] = '0;
      conv(op, fb, 1'($urandom()), 1'($urandom()), 1'($urandom()),
           (k == 10) ? "R2" : (k == 11) ? "R10" : "R4");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule